// File: doc/BRIEF.md
# Interrupt-Enable Register Pair with Guest Supervisor View

This block holds two machine-level control registers of a hart that supports a hypervisor extension. The first is the interrupt-enable word, with one bit per interrupt source. The second is the delegation word, which marks which interrupt sources are handed down to lower privilege levels. The block also provides a third address: a supervisor-level window onto the enable word. Through that window, software sees and changes only the enable bits that belong to it.

The window depends on a virtualization-mode input. With the input low, the window maps onto the native supervisor trio of enables: software, timer and external. With it high, the same window maps onto the guest-supervisor trio, which sits one bit above the native trio. Each bit is relocated by one position on the way out and on the way in. Every access arrives on a simple register port that carries an address, a read strobe, a write strobe, write data and read data.

Top module: `irq_ie_csr`

## Requirements
- R1: After reset, reading the enable address, the delegation address and the supervisor window in either mode returns zero.
- R2: A write to the enable address stores only the legal bits and clears all others. The legal bits are positions 1, 5 and 9 (native supervisor), 2, 6 and 10 (guest supervisor) and 3, 7 and 11 (machine), which is mask 0xEEE.
- R3: A write to the delegation address stores only the delegable bits, positions 1, 2, 5, 6, 9 and 10 (mask 0x666), and clears all others.
- R4: With the mode input low, reading the supervisor window returns the enable word ANDed with the delegation word.
- R5: With the mode input high, reading the supervisor window returns the enable word ANDed with the delegation word and with 0x444, shifted right by one bit.
- R6: With the mode input low, a write to the supervisor window replaces enable bits 1, 5 and 9 with the same bits of the write data. Every other enable bit keeps its value.
- R7: With the mode input high, a write to the supervisor window replaces enable bits 2, 6 and 10 with write-data bits 1, 5 and 9. Every other enable bit keeps its value, and bits that the shift moves outside 0xEEE are dropped.
- R8: A write to any other address changes no register. A read of any other address returns zero, and the read data is zero whenever the read strobe is low.
- R9: Read data follows the address combinationally. A write takes effect on the clock edge that samples the write strobe, so a read of the same address in that cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| virt_i | input | 1 | Virtualization mode; high redirects the supervisor window to the guest trio |
| csr_addr_i | input | AW | Register address |
| csr_rd_i | input | 1 | Read strobe |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data; zero when not reading |

## Verification
Walking-one patterns across the full data width, written to the enable and delegation addresses, show which single bit positions are kept and which are dropped by each legal mask. Random enable and delegation pairs are read through the window in both modes. This shows the delegation AND apart from the one-bit relocation and the guest-trio mask. Random window writes in both modes, each followed by a read of the full enable word, show that only the targeted trio changes. Writes and reads at unmapped addresses, together with reads made with the strobe low, confirm that those accesses have no effect.

// File: rtl/irq_ie_pkg.sv
package irq_ie_pkg;

   localparam int unsigned IRQ_BITS = 12;

   localparam int unsigned POS_S_SW   = 1;
   localparam int unsigned POS_G_SW   = 2;
   localparam int unsigned POS_M_SW   = 3;
   localparam int unsigned POS_S_TMR  = 5;
   localparam int unsigned POS_G_TMR  = 6;
   localparam int unsigned POS_M_TMR  = 7;
   localparam int unsigned POS_S_EXT  = 9;
   localparam int unsigned POS_G_EXT  = 10;
   localparam int unsigned POS_M_EXT  = 11;

   localparam logic [IRQ_BITS-1:0] SUP_GRP =
      IRQ_BITS'((1 << POS_S_SW) | (1 << POS_S_TMR) | (1 << POS_S_EXT));
   localparam logic [IRQ_BITS-1:0] GST_GRP =
      IRQ_BITS'((1 << POS_G_SW) | (1 << POS_G_TMR) | (1 << POS_G_EXT));
   localparam logic [IRQ_BITS-1:0] MCH_GRP =
      IRQ_BITS'((1 << POS_M_SW) | (1 << POS_M_TMR) | (1 << POS_M_EXT));

   localparam logic [IRQ_BITS-1:0] DELEGABLE = SUP_GRP | GST_GRP;
   localparam logic [IRQ_BITS-1:0] LEGAL_EN  = MCH_GRP | SUP_GRP | GST_GRP;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_EN    = 2'd1,
      SEL_DELEG = 2'd2,
      SEL_VIEW  = 2'd3
   } csr_sel_e;

endpackage

// File: rtl/irq_ie_decode.sv
module irq_ie_decode
   import irq_ie_pkg::*;
#(
   parameter int unsigned    AW         = 12,
   parameter logic [AW-1:0]  ADDR_EN    = AW'(12'h304),
   parameter logic [AW-1:0]  ADDR_DELEG = AW'(12'h303),
   parameter logic [AW-1:0]  ADDR_VIEW  = AW'(12'h104)
) (
   input  logic [AW-1:0] addr_i,
   output csr_sel_e      sel_o
);

   if ((ADDR_EN == ADDR_DELEG) || (ADDR_EN == ADDR_VIEW) || (ADDR_DELEG == ADDR_VIEW)) begin : g_addr_clash
      $error("irq_ie_decode: register addresses must be distinct");
   end

   always_comb begin
      if (addr_i == ADDR_EN)         sel_o = SEL_EN;
      else if (addr_i == ADDR_DELEG) sel_o = SEL_DELEG;
      else if (addr_i == ADDR_VIEW)  sel_o = SEL_VIEW;
      else                           sel_o = SEL_NONE;
   end

endmodule

// File: rtl/irq_ie_maskreg.sv
module irq_ie_maskreg #(
   parameter int unsigned      XLEN = 32,
   parameter logic [XLEN-1:0]  KEEP = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [XLEN-1:0] d_i,
   output logic [XLEN-1:0] q_o
);

   logic unused_bits;
   assign unused_bits = ^(d_i & ~KEEP);

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (KEEP[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q_o[i] <= 1'b0;
            else if (we_i) q_o[i] <= d_i[i];
         end
      end else begin : g_tie
         assign q_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_ie_sview.sv
module irq_ie_sview
   import irq_ie_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          VIRT_EN = 1'b1
) (
   input  logic            virt_i,
   input  logic [XLEN-1:0] en_i,
   input  logic [XLEN-1:0] deleg_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] view_o,
   output logic [XLEN-1:0] merged_o
);

   localparam logic [XLEN-1:0] SUP_W = XLEN'(SUP_GRP);
   localparam logic [XLEN-1:0] GST_W = XLEN'(GST_GRP);

   logic [XLEN-1:0] native_view;
   logic [XLEN-1:0] native_merge;

   assign native_view  = en_i & deleg_i;
   assign native_merge = (en_i & ~SUP_W) | (wdata_i & SUP_W);

   if (VIRT_EN) begin : g_virt
      logic [XLEN-1:0] guest_view;
      logic [XLEN-1:0] guest_merge;
      assign guest_view  = (en_i & deleg_i & GST_W) >> 1;
      assign guest_merge = (en_i & ~GST_W) | ((wdata_i << 1) & GST_W);
      assign view_o      = virt_i ? guest_view  : native_view;
      assign merged_o    = virt_i ? guest_merge : native_merge;
   end else begin : g_native
      logic unused_virt;
      assign unused_virt = virt_i;
      assign view_o      = native_view;
      assign merged_o    = native_merge;
   end

endmodule

// File: rtl/irq_ie_csr.sv
module irq_ie_csr
   import irq_ie_pkg::*;
#(
   parameter int unsigned    XLEN       = 32,
   parameter int unsigned    AW         = 12,
   parameter logic [AW-1:0]  ADDR_EN    = AW'(12'h304),
   parameter logic [AW-1:0]  ADDR_DELEG = AW'(12'h303),
   parameter logic [AW-1:0]  ADDR_VIEW  = AW'(12'h104),
   parameter bit             VIRT_EN    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            virt_i,
   input  logic [AW-1:0]   csr_addr_i,
   input  logic            csr_rd_i,
   input  logic            csr_we_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic [XLEN-1:0] csr_rdata_o
);

   localparam logic [XLEN-1:0] LEGAL_W = XLEN'(LEGAL_EN);
   localparam logic [XLEN-1:0] DELEG_W = XLEN'(DELEGABLE);

   if (XLEN < IRQ_BITS) begin : g_xlen_small
      $error("irq_ie_csr: XLEN must cover all interrupt bits");
   end
   if (AW < 1) begin : g_aw_zero
      $error("irq_ie_csr: AW must be positive");
   end

   csr_sel_e        sel;
   logic [XLEN-1:0] m_en_q;
   logic [XLEN-1:0] deleg_q;
   logic [XLEN-1:0] view_rd;
   logic [XLEN-1:0] view_merged;
   logic            en_we;
   logic            deleg_we;
   logic [XLEN-1:0] en_d;
   logic [XLEN-1:0] rd_mux;

   irq_ie_decode #(
      .AW         (AW),
      .ADDR_EN    (ADDR_EN),
      .ADDR_DELEG (ADDR_DELEG),
      .ADDR_VIEW  (ADDR_VIEW)
   ) u_decode (
      .addr_i (csr_addr_i),
      .sel_o  (sel)
   );

   irq_ie_sview #(
      .XLEN    (XLEN),
      .VIRT_EN (VIRT_EN)
   ) u_sview (
      .virt_i   (virt_i),
      .en_i     (m_en_q),
      .deleg_i  (deleg_q),
      .wdata_i  (csr_wdata_i),
      .view_o   (view_rd),
      .merged_o (view_merged)
   );

   assign en_we    = csr_we_i && ((sel == SEL_EN) || (sel == SEL_VIEW));
   assign en_d     = (sel == SEL_VIEW) ? view_merged : csr_wdata_i;
   assign deleg_we = csr_we_i && (sel == SEL_DELEG);

   irq_ie_maskreg #(
      .XLEN (XLEN),
      .KEEP (LEGAL_W)
   ) u_en_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (en_we),
      .d_i   (en_d),
      .q_o   (m_en_q)
   );

   irq_ie_maskreg #(
      .XLEN (XLEN),
      .KEEP (DELEG_W)
   ) u_deleg_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (deleg_we),
      .d_i   (csr_wdata_i),
      .q_o   (deleg_q)
   );

   always_comb begin
      unique case (sel)
         SEL_EN:    rd_mux = m_en_q;
         SEL_DELEG: rd_mux = deleg_q;
         SEL_VIEW:  rd_mux = view_rd;
         default:   rd_mux = '0;
      endcase
   end

   assign csr_rdata_o = csr_rd_i ? rd_mux : '0;

endmodule

// File: rtl/irq_ie_csr_chk.sv
module irq_ie_csr_chk
   import irq_ie_pkg::*;
#(
   parameter int unsigned    XLEN       = 32,
   parameter int unsigned    AW         = 12,
   parameter logic [AW-1:0]  ADDR_EN    = AW'(12'h304),
   parameter logic [AW-1:0]  ADDR_DELEG = AW'(12'h303),
   parameter logic [AW-1:0]  ADDR_VIEW  = AW'(12'h104)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            virt_i,
   input logic [AW-1:0]   csr_addr_i,
   input logic            csr_rd_i,
   input logic            csr_we_i,
   input logic [XLEN-1:0] csr_rdata_o,
   input logic [XLEN-1:0] m_en_q,
   input logic [XLEN-1:0] deleg_q
);

   localparam logic [XLEN-1:0] LEGAL_W = XLEN'(LEGAL_EN);
   localparam logic [XLEN-1:0] DELEG_W = XLEN'(DELEGABLE);
   localparam logic [XLEN-1:0] MCH_W   = XLEN'(MCH_GRP);
   localparam logic [XLEN-1:0] SUP_W   = XLEN'(SUP_GRP);

   p_en_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_i && csr_addr_i == ADDR_EN) |-> ((csr_rdata_o & ~LEGAL_W) == '0));

   p_deleg_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_i && csr_addr_i == ADDR_DELEG) |-> ((csr_rdata_o & ~DELEG_W) == '0));

   p_view_native_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_i && csr_addr_i == ADDR_VIEW && !virt_i) |-> ((csr_rdata_o & ~DELEG_W) == '0));

   p_view_guest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_i && csr_addr_i == ADDR_VIEW && virt_i) |-> ((csr_rdata_o & ~SUP_W) == '0));

   p_view_wr_keeps_mach_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we_i && csr_addr_i == ADDR_VIEW) |=> ((m_en_q & MCH_W) == $past(m_en_q & MCH_W)));

   p_guest_wr_keeps_sup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we_i && csr_addr_i == ADDR_VIEW && virt_i) |=> ((m_en_q & SUP_W) == $past(m_en_q & SUP_W)));

   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_we_i |=> ($stable(m_en_q) && $stable(deleg_q)));

   p_no_strobe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_rd_i |-> (csr_rdata_o == '0));

endmodule

bind irq_ie_csr irq_ie_csr_chk #(
   .XLEN       (XLEN),
   .AW         (AW),
   .ADDR_EN    (ADDR_EN),
   .ADDR_DELEG (ADDR_DELEG),
   .ADDR_VIEW  (ADDR_VIEW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .virt_i      (virt_i),
   .csr_addr_i  (csr_addr_i),
   .csr_rd_i    (csr_rd_i),
   .csr_we_i    (csr_we_i),
   .csr_rdata_o (csr_rdata_o),
   .m_en_q      (m_en_q),
   .deleg_q     (deleg_q)
);

// File: tb/irq_ie_csr_bench.sv
module irq_ie_csr_bench;

   localparam int CLK_P = 10;
   localparam int XLEN  = 32;
   localparam int AW    = 12;
   localparam logic [AW-1:0] A_EN    = 12'h304;
   localparam logic [AW-1:0] A_DELEG = 12'h303;
   localparam logic [AW-1:0] A_VIEW  = 12'h104;

   localparam logic [XLEN-1:0] G_SUP = (32'd1 << 1) | (32'd1 << 5) | (32'd1 << 9);
   localparam logic [XLEN-1:0] G_GST = (32'd1 << 2) | (32'd1 << 6) | (32'd1 << 10);
   localparam logic [XLEN-1:0] G_MCH = (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 11);
   localparam logic [XLEN-1:0] M_LEGAL = G_SUP | G_GST | G_MCH;
   localparam logic [XLEN-1:0] M_DELEG = G_SUP | G_GST;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            virt_i = 1'b0;
   logic [AW-1:0]   csr_addr_i = '0;
   logic            csr_rd_i = 1'b0;
   logic            csr_we_i = 1'b0;
   logic [XLEN-1:0] csr_wdata_i = '0;
   logic [XLEN-1:0] csr_rdata_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [XLEN-1:0] mdl_en = '0;
   logic [XLEN-1:0] mdl_dl = '0;
   logic [31:0]     seed = 32'h1234_5678;

   always #(CLK_P/2) clk = ~clk;

   irq_ie_csr #(.XLEN(XLEN), .AW(AW)) u_irq_ie_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .virt_i      (virt_i),
      .csr_addr_i  (csr_addr_i),
      .csr_rd_i    (csr_rd_i),
      .csr_we_i    (csr_we_i),
      .csr_wdata_i (csr_wdata_i),
      .csr_rdata_o (csr_rdata_o)
   );

   function automatic logic [XLEN-1:0] exp_rd(logic [AW-1:0] a, logic v);
      if (a == A_EN)         return mdl_en;
      else if (a == A_DELEG) return mdl_dl;
      else if (a == A_VIEW)  return v ? ((mdl_en & mdl_dl & G_GST) >> 1) : (mdl_en & mdl_dl);
      else                   return '0;
   endfunction

   function automatic logic [31:0] nxt_rand(logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic v, input string req);
      @(negedge clk);
      csr_addr_i = a; virt_i = v; csr_rd_i = 1'b1;
      #1;
      chk(req, csr_rdata_o, exp_rd(a, v));
      csr_rd_i = 1'b0;
   endtask

   // R9: during the write cycle the read still shows the old value
   task automatic wr(input logic [AW-1:0] a, input logic [XLEN-1:0] d, input logic v);
      logic [XLEN-1:0] ne;
      logic [XLEN-1:0] nd;
      @(negedge clk);
      csr_addr_i = a; csr_wdata_i = d; virt_i = v; csr_we_i = 1'b1; csr_rd_i = 1'b1;
      #1;
      chk("R9", csr_rdata_o, exp_rd(a, v));
      ne = mdl_en; nd = mdl_dl;
      if (a == A_EN) ne = d & M_LEGAL;
      else if (a == A_DELEG) nd = d & M_DELEG;
      else if (a == A_VIEW) begin
         if (v) ne = ((mdl_en & ~G_GST) | ((d << 1) & G_GST)) & M_LEGAL;
         else   ne = ((mdl_en & ~G_SUP) | (d & G_SUP)) & M_LEGAL;
      end
      @(negedge clk);
      csr_we_i = 1'b0; csr_rd_i = 1'b0;
      mdl_en = ne; mdl_dl = nd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(A_EN, 1'b0, "R1");
      rd(A_DELEG, 1'b0, "R1");
      rd(A_VIEW, 1'b0, "R1");
      rd(A_VIEW, 1'b1, "R1");

      // R2 / R3: walking ones across the whole width
      for (int i = 0; i < XLEN; i++) begin
         wr(A_EN, 32'd1 << i, 1'b0);
         rd(A_EN, 1'b0, "R2");
         wr(A_DELEG, 32'd1 << i, 1'b1);
         rd(A_DELEG, 1'b0, "R3");
      end
      wr(A_EN, '1, 1'b0);
      chk("R2", mdl_en, 32'h0000_0EEE);
      rd(A_EN, 1'b0, "R2");
      wr(A_DELEG, '1, 1'b0);
      rd(A_DELEG, 1'b0, "R3");

      // R4 R5 R6 R7: random register pairs through the window in both modes
      for (int k = 0; k < 300; k++) begin
         seed = nxt_rand(seed); wr(A_EN, seed, seed[20]);
         seed = nxt_rand(seed); wr(A_DELEG, seed, 1'b0);
         rd(A_VIEW, 1'b0, "R4");
         rd(A_VIEW, 1'b1, "R5");
         seed = nxt_rand(seed); wr(A_VIEW, seed, 1'b0);
         rd(A_EN, 1'b0, "R6");
         seed = nxt_rand(seed); wr(A_VIEW, seed, 1'b1);
         rd(A_EN, 1'b1, "R7");
      end

      // R7 corner: all-ones guest write sets only the guest trio
      wr(A_EN, '0, 1'b0);
      wr(A_VIEW, '1, 1'b1);
      rd(A_EN, 1'b0, "R7");
      chk("R7", mdl_en, 32'h0000_0444);

      // R8: unmapped addresses and an idle read strobe
      wr(A_EN, 32'h0000_0A5A, 1'b0);
      wr(A_DELEG, 32'h0000_0246, 1'b0);
      for (int k = 0; k < 8; k++) begin
         seed = nxt_rand(seed);
         wr(12'h305 + AW'(k), seed, k[0]);
         rd(A_EN, 1'b0, "R8");
         rd(A_DELEG, 1'b0, "R8");
         rd(12'h105 + AW'(k), k[0], "R8");
      end
      @(negedge clk);
      csr_addr_i = A_EN; csr_rd_i = 1'b0;
      #1;
      chk("R8", csr_rdata_o, '0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule